// File: doc/BRIEF.md
# APB Bridge to a Clock-Enabled Slow Register Bank

This block is an APB subordinate fronting a small register bank that is modelled as living on a slower clock. All flops run on the bus clock. The bank only advances on an enable pulse, and that pulse comes from a divider whose ratio is a runtime input. A power gate input can also mask the pulse, standing in for a clock that has been switched off.

A bus request is captured in its setup cycle. The bridge then holds `pready` low until the first usable enable pulse. The read or write happens on that pulse, and completion is signalled in the cycle that follows. The number of wait states is therefore set by the divide ratio, the divider phase and the gate, not by the bus.

Word 0 of the bank is a read-only count of the enable pulses the slow logic has seen. A read of word 0 therefore shows directly how far the slow side has advanced. The other words are plain read/write storage.

Top module: `apb_slowclk_bridge`

## Requirements
- R1: While `rst_n` is low and after its release, `pready` is 1 and `prdata` is 0. Every bank word starts at 0, and the divider count starts at 0.
- R2: `div_ratio` is an unsigned value. A value of 0 acts as 1, and values above 8 act as 8. With an effective ratio N held constant, an enable pulse occurs in the N-th cycle after reset and then every N cycles. With N = 1 the pulse is present in every cycle.
- R3: With no transfer in progress, and whenever `psel` is 0, `pready` is 1.
- R4: `paddr`, `pwrite` and `pwdata` are captured in the setup cycle (`psel`=1, `penable`=0). Changes on these inputs afterwards have no effect on the transfer.
- R5: A captured transfer executes on the first cycle after its setup cycle in which the enable pulse is present and `gate_open` is 1. A pulse during the setup cycle itself does not execute it. `pready` stays 0 until the transfer executes.
- R6: `pready` is 1 in the cycle after the executing pulse. That cycle is the completing access cycle, and there is exactly one such cycle per transfer.
- R7: With `gate_open` held at 1 and an effective ratio N held constant, each transfer takes between 1 and N wait cycles (access cycles with `pready` = 0).
- R8: While `gate_open` is 0, no transfer executes and the pulse counter does not advance. If the gate is closed for the first G access cycles, the transfer takes between G+1 and G+N wait cycles.
- R9: The word index is `paddr[3:2]` and all other address bits are ignored. Index 0 reads the number of gated pulses seen before the executing pulse; writes to index 0 are ignored. Indices 1 to 3 are 32-bit read/write words.
- R10: A read returns the addressed word as it stood at the executing pulse. `prdata` holds that value until the next read executes, and writes do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; every flop uses it |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte address; bits 3:2 pick the word |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, registered |
| pready | output | 1 | Transfer completion / wait control |
| div_ratio | input | 4 | Slow-clock divide ratio (effective 1..8) |
| gate_open | input | 1 | 1 = slow clock running, 0 = gated off |

## Verification
An enable pulse can fall in the same cycle as the setup phase that captures a request. That pulse must be passed over, and the transfer must wait for the next one. The bench provokes this by inserting 0 to N-1 idle cycles before transfers at every ratio, which slides the divider phase across the setup cycle.

The gate reopening can also coincide with a pulse. Closing the gate for a set number of access cycles places the reopening at several pulse phases. Both situations are judged by a behavioural per-cycle model of `pready`, `prdata` and the pulse count, and by checking each measured wait count against its allowed window.

// File: rtl/slowbr_pkg.sv
package slowbr_pkg;

    typedef enum logic [1:0] {
        BR_IDLE = 2'd0,
        BR_PEND = 2'd1,
        BR_RESP = 2'd2
    } br_state_e;

endpackage

// File: rtl/slowbr_divider.sv
module slowbr_divider #(
    parameter int RATIO_W   = 4,
    parameter int MAX_RATIO = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio,
    output logic               tick
);
    localparam int CNT_W = (MAX_RATIO > 1) ? $clog2(MAX_RATIO) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q, lim;

    always_comb begin
        if (ratio == '0) begin
            lim = '0;
        end else if (int'(ratio) > MAX_RATIO) begin
            lim = CNT_W'(MAX_RATIO - 1);
        end else begin
            lim = CNT_W'(ratio - 1'b1);
        end
        tick  = (cnt_q >= lim);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R2
    pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim != '0 && $past(tick)) |-> !tick);

endmodule

// File: rtl/slowbr_regbank.sv
module slowbr_regbank #(
    parameter int NREGS = 4,
    parameter int DW    = 32,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse,
    input  logic             acc,
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] val [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [DW-1:0] r_d, r_q;

        if (g == 0) begin : g_cnt
            always_comb r_d = pulse ? r_q + 1'b1 : r_q;

            // R9
            cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(r_q) |-> (r_q == $past(r_q) + 1'b1));
        end else begin : g_rw
            always_comb r_d = (acc && wr && idx == IDX_W'(g)) ? wdata : r_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else begin
                r_q <= r_d;
            end
        end

        assign val[g] = r_q;
    end

    assign rdata = val[idx];

endmodule

// File: rtl/apb_slowclk_bridge.sv
module apb_slowclk_bridge
    import slowbr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NREGS     = 4,
    parameter int RATIO_W   = 4,
    parameter int MAX_RATIO = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    output logic [DATA_W-1:0]  prdata,
    output logic               pready,
    input  logic [RATIO_W-1:0] div_ratio,
    input  logic               gate_open
);
    localparam int IDX_W   = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam int IDX_LSB = 2;

    typedef struct packed {
        br_state_e         state;
        logic [IDX_W-1:0]  idx;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              ready;
        logic [DATA_W-1:0] rdata;
    } br_regs_t;

    br_regs_t          st_d, st_q;
    logic              tick, slow_en, exec;
    logic [DATA_W-1:0] bank_rdata;

    slowbr_divider #(
        .RATIO_W   (RATIO_W),
        .MAX_RATIO (MAX_RATIO)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .ratio (div_ratio),
        .tick  (tick)
    );

    assign slow_en = tick && gate_open;
    assign exec    = (st_q.state == BR_PEND) && slow_en;

    slowbr_regbank #(
        .NREGS (NREGS),
        .DW    (DATA_W),
        .IDX_W (IDX_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .pulse (slow_en),
        .acc   (exec),
        .wr    (st_q.wr),
        .idx   (st_q.idx),
        .wdata (st_q.wdata),
        .rdata (bank_rdata)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.state)
            BR_IDLE: begin
                st_d.ready = 1'b1;
                if (psel && !penable) begin
                    st_d.state = BR_PEND;
                    st_d.idx   = paddr[IDX_LSB +: IDX_W];
                    st_d.wr    = pwrite;
                    st_d.wdata = pwdata;
                    st_d.ready = 1'b0;
                end
            end
            BR_PEND: begin
                if (exec) begin
                    st_d.state = BR_RESP;
                    st_d.ready = 1'b1;
                    if (!st_q.wr) begin
                        st_d.rdata = bank_rdata;
                    end
                end
            end
            BR_RESP: begin
                st_d.state = BR_IDLE;
                st_d.ready = 1'b1;
            end
            default: begin
                st_d.state = BR_IDLE;
                st_d.ready = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: BR_IDLE, idx: '0, wr: 1'b0, wdata: '0,
                      ready: 1'b1, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pready = st_q.ready;
    assign prdata = st_q.rdata;

    // R6
    done_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pready) |-> $past(slow_en));

    // R8
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == BR_PEND && !gate_open) |=> !pready);

    // R3
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !psel |-> pready);

endmodule

// File: tb/apb_slowclk_bridge_bench.sv
module apb_slowclk_bridge_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, gate_open = 1'b1;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  div_ratio = 4'd4;
    logic [31:0] prdata;
    logic        pready;

    int    vectors = 0;
    int    fails = 0;
    bit    done_flag = 1'b0;
    string phase = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    apb_slowclk_bridge u_apb_slowclk_bridge (
        .clk       (clk),
        .rst_n     (rst_n),
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .paddr     (paddr),
        .pwdata    (pwdata),
        .prdata    (prdata),
        .pready    (pready),
        .div_ratio (div_ratio),
        .gate_open (gate_open)
    );

    // ---------------- behavioural reference model ----------------
    int          m_since, m_state, m_idx;
    bit          m_wr, exp_ready;
    logic [31:0] m_wd, m_cnt, exp_rdata;
    logic [31:0] m_regs [4];

    function automatic int eff_of(input logic [3:0] r);
        if (r == 4'd0) return 1;
        if (r > 4'd8) return 8;
        return int'(r);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_since = 0; m_state = 0; m_idx = 0; m_wr = 0; m_wd = '0;
            m_cnt = '0; exp_rdata = '0; exp_ready = 1'b1;
            for (int i = 0; i < 4; i++) m_regs[i] = '0;
        end else begin : mdl
            bit tk, pu;
            tk = (m_since >= eff_of(div_ratio) - 1);
            pu = tk && gate_open;
            m_since = tk ? 0 : m_since + 1;
            case (m_state)
                0: begin
                    exp_ready = 1'b1;
                    if (psel && !penable) begin
                        m_state = 1;
                        m_idx = int'((paddr >> 2) & 8'd3);
                        m_wr = pwrite;
                        m_wd = pwdata;
                        exp_ready = 1'b0;
                    end
                end
                1: begin
                    if (pu) begin
                        if (m_wr) begin
                            if (m_idx != 0) m_regs[m_idx] = m_wd;
                        end else begin
                            exp_rdata = (m_idx == 0) ? m_cnt : m_regs[m_idx];
                        end
                        m_state = 2;
                        exp_ready = 1'b1;
                    end
                end
                default: begin
                    m_state = 0;
                    exp_ready = 1'b1;
                end
            endcase
            if (pu) m_cnt = m_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            vectors++;
            if (pready !== exp_ready) begin
                fails++;
                $display("FAIL %s pready act=%0b exp=%0b at %0t",
                         (m_state == 0) ? "R3" : ((m_state == 1) ? "R5" : "R6"),
                         pready, exp_ready, $time);
            end
            if (prdata !== exp_rdata) begin
                fails++;
                $display("FAIL R10 (%s) prdata act=%h exp=%h at %0t",
                         phase, prdata, exp_rdata, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            psel = 1'b0;
            penable = 1'b0;
        end
    endtask

    task automatic xfer(input bit wr, input logic [7:0] addr, input logic [31:0] data,
                        input int gate_off, input bit jitter, output int waits);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = addr; pwdata = data;
        if (gate_off > 0) gate_open = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        waits = 0;
        for (int k = 0; k < 5000; k++) begin
            if (pready) break;
            waits++;
            if (jitter) begin
                paddr = paddr ^ 8'h0C;
                pwdata = ~pwdata;
                pwrite = ~pwrite;
            end
            if (gate_off > 0 && waits == gate_off + 1) gate_open = 1'b1;
            @(negedge clk);
        end
        gate_open = 1'b1;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R5) act=hung exp=complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        int w, w2;
        logic [31:0] a, b, dat;

        repeat (3) @(negedge clk);
        check(pready === 1'b1, "R1", "pready in reset", pready, 1);
        check(prdata === 32'd0, "R1", "prdata in reset", prdata, 0);
        rst_n = 1'b1;

        // R1: every rw word reads zero after reset
        phase = "R1";
        for (int i = 1; i < 4; i++) begin
            xfer(1'b0, 8'(i * 4), '0, 0, 1'b0, w);
            check(prdata == 32'd0, "R1", "word after reset", prdata, 0);
        end

        // R5 R6 R7: sweep ratio and divider phase
        phase = "R7";
        for (int r = 1; r <= 8; r++) begin
            div_ratio = 4'(r);
            for (int p = 0; p < r; p++) begin
                dat = 32'h1000_0000 + 32'(r * 16 + p);
                idle(p);
                xfer(1'b1, 8'(((p % 3) + 1) * 4), dat, 0, 1'b0, w);
                check(w >= 1 && w <= r, "R7", "write waits", w, r);
                idle((p + 1) % r);
                xfer(1'b0, 8'(((p % 3) + 1) * 4), '0, 0, 1'b0, w);
                check(w >= 1 && w <= r, "R7", "read waits", w, r);
                check(prdata == dat, "R10", "readback", prdata, dat);
            end
        end

        // R2: ratio clamping
        phase = "R2";
        div_ratio = 4'd0;
        xfer(1'b0, 8'h00, '0, 0, 1'b0, w);
        check(w == 1, "R2", "ratio 0 waits", w, 1);
        a = prdata;
        xfer(1'b0, 8'h00, '0, 0, 1'b0, w);
        b = prdata;
        check(b - a == 32'd3, "R2", "ratio 0 pulse spacing", b - a, 3);
        div_ratio = 4'd12;
        for (int p = 0; p < 8; p++) begin
            idle(p);
            xfer(1'b0, 8'h08, '0, 0, 1'b0, w);
            check(w >= 1 && w <= 8, "R2", "ratio 12 waits", w, 8);
        end

        // R9: read-only counter word, address aliasing
        phase = "R9";
        div_ratio = 4'd1;
        xfer(1'b0, 8'h00, '0, 0, 1'b0, w);
        a = prdata;
        xfer(1'b1, 8'h00, 32'hDEAD_BEEF, 0, 1'b0, w);
        xfer(1'b0, 8'h00, '0, 0, 1'b0, w);
        b = prdata;
        check(b - a == 32'd6, "R9", "counter word ignores write", b - a, 6);
        xfer(1'b1, 8'hE4, 32'hA5A5_0001, 0, 1'b0, w);
        xfer(1'b0, 8'h07, '0, 0, 1'b0, w);
        check(prdata == 32'hA5A5_0001, "R9", "aliased word 1", prdata, 32'hA5A5_0001);

        // R4: request inputs change during access phase
        phase = "R4";
        div_ratio = 4'd8;
        xfer(1'b1, 8'h0C, 32'h3333_3333, 0, 1'b0, w);
        xfer(1'b1, 8'h08, 32'h2222_2222, 0, 1'b1, w);
        xfer(1'b0, 8'h08, '0, 0, 1'b0, w);
        check(prdata == 32'h2222_2222, "R4", "jittered write kept", prdata, 32'h2222_2222);
        xfer(1'b0, 8'h0C, '0, 0, 1'b1, w);
        check(prdata == 32'h3333_3333, "R4", "jittered read kept", prdata, 32'h3333_3333);

        // R10: a write leaves prdata untouched
        phase = "R10";
        xfer(1'b1, 8'h04, 32'h7777_0000, 0, 1'b0, w);
        check(prdata == 32'h3333_3333, "R10", "prdata held over write", prdata, 32'h3333_3333);

        // R8: gate closed during the access phase
        phase = "R8";
        div_ratio = 4'd3;
        xfer(1'b1, 8'h04, 32'h0808_0808, 5, 1'b0, w);
        check(w >= 6 && w <= 8, "R8", "gated write waits", w, 6);
        xfer(1'b0, 8'h04, '0, 13, 1'b0, w2);
        check(w2 >= 14 && w2 <= 16, "R8", "gated read waits", w2, 14);
        check(prdata == 32'h0808_0808, "R8", "gated readback", prdata, 32'h0808_0808);
        // gate closed while idle: counter must not move
        xfer(1'b0, 8'h00, '0, 0, 1'b0, w);
        a = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; gate_open = 1'b0;
        repeat (20) @(negedge clk);
        gate_open = 1'b1;
        xfer(1'b0, 8'h00, '0, 0, 1'b0, w);
        b = prdata;
        check(b - a <= 32'd3, "R8", "counter frozen while gated", b - a, 3);

        idle(4);
        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule